// File: doc/BRIEF.md
# Configuration Mode Unlock Detector

This block watches byte writes on an I/O bus and opens access to a configuration register space only after a fixed four-byte unlock sequence arrives at its index port. The block is strapped by a parameter to one of two base addresses. The index port is the base address and the data port is the base plus one. The last byte of the sequence depends on that strap, so each instance has its own key. While the space is open, the level output `cfg_active` is high. Other logic uses this level to qualify its own decoding of the configuration registers.

A byte that breaks a partial sequence sends the machine back to its start. If that breaking byte is the first sequence byte, the machine instead resumes just past the first step. Each such abandoned sequence sets a sticky flag, and a read strobe clears it. Software leaves configuration mode by selecting the control index through the index port and then writing the exit value through the data port.

Write bytes enter as a valid-only stream. The block accepts a byte in every cycle where `io_wr_valid` is high and never applies back-pressure, so there is no ready signal. A beat is consumed at the rising clock edge where it is valid.

Top module: `cfgu_unlock`

## Requirements
- R1: While `rst` is high at a rising edge, the sequence returns to its start, `cfg_active` goes low and `mismatch_flag` goes low after that edge.
- R2: Four accepted writes to the index port carrying 0x87, 0x01, 0x55 and then the key byte make `cfg_active` high right after the edge that accepts the fourth byte. Writes to other addresses and idle cycles may come between the four bytes.
- R3: With `ALT_BASE`=0 the index port is 0x2E, the data port is 0x2F and the key byte is 0x55. With `ALT_BASE`=1 the index port is 0x4E, the data port is 0x4F and the key byte is 0xAA. At the primary base, a final byte of 0xAA does not unlock.
- R4: During a partial sequence, an index write that does not match the next expected byte returns the machine to its start. When that wrong byte is 0x87, the machine instead moves to the state that follows the first byte.
- R5: `mismatch_flag` sets right after an edge that accepts a wrong byte during a partial sequence. A byte other than 0x87 written while no sequence is in progress does not set it.
- R6: A `flag_rd` pulse clears `mismatch_flag` after that edge. When a set and a clear fall on the same edge, the set wins.
- R7: While `cfg_active` is high, an index write of 0x02 followed later by a data-port write of 0x02 drops `cfg_active` after the data write's edge. A data write of any other value, or an intervening index write other than 0x02, does not exit.
- R8: Writes to any address other than the index and data ports are ignored. Data-port writes are ignored while locked. Index writes made while unlocked only select an index and never relock.
- R9: Cycles with `io_wr_valid` low leave both outputs unchanged, apart from the clearing caused by `flag_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| io_wr_valid | input | 1 | A write beat is present this cycle |
| io_addr | input | ADDR_W | I/O address of the write beat |
| io_wdata | input | 8 | Data byte of the write beat |
| flag_rd | input | 1 | Read strobe that clears the mismatch flag |
| cfg_active | output | 1 | Configuration mode is open |
| mismatch_flag | output | 1 | Sticky marker of an abandoned partial sequence |

## Verification
The hardest situations to reach are deep partial sequences that break on a byte of 0x87, and exit attempts where other index writes come between the control-index selection and the data write. Uniform random bytes almost never reach either. The random stimulus therefore draws mostly from the sequence bytes and the exit value, and it concentrates addresses on the index and data ports. Directed cases add the restart from every partial depth, the wrong key at the primary base, and a set and a clear of the flag on the same edge.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,
    ST_K2   = 3'd2,
    ST_K3   = 3'd3,
    ST_OPEN = 3'd4
  } cfgu_state_e;

  localparam logic [BYTE_W-1:0] SEQ_B0   = 8'h87;
  localparam logic [BYTE_W-1:0] SEQ_B1   = 8'h01;
  localparam logic [BYTE_W-1:0] SEQ_B2   = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_PRI  = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_ALT  = 8'hAA;
  localparam logic [BYTE_W-1:0] CTRL_IDX = 8'h02;
  localparam logic [BYTE_W-1:0] EXIT_VAL = 8'h02;
  localparam int BASE_PRI = 'h2E;
  localparam int BASE_ALT = 'h4E;

  function automatic logic [BYTE_W-1:0] next_byte(cfgu_state_e st,
                                                  logic [BYTE_W-1:0] key);
    case (st)
      ST_IDLE: next_byte = SEQ_B0;
      ST_K1:   next_byte = SEQ_B1;
      ST_K2:   next_byte = SEQ_B2;
      default: next_byte = key;
    endcase
  endfunction
endpackage

// File: rtl/cfgu_port_decode.sv
module cfgu_port_decode
  import cfgu_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter bit ALT_BASE = 1'b0
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              idx_wr,
  output logic              dat_wr,
  output logic [BYTE_W-1:0] key
);
  localparam int BASE_SEL = ALT_BASE ? BASE_ALT : BASE_PRI;
  localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE_SEL);
  localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE_SEL + 1);

  generate
    if (ALT_BASE) begin : g_alt
      assign key = KEY_ALT;
    end else begin : g_pri
      assign key = KEY_PRI;
    end
  endgenerate

  assign idx_wr = valid && (addr == IDX_ADDR);
  assign dat_wr = valid && (addr == DAT_ADDR);
endmodule

// File: rtl/cfgu_seq_fsm.sv
module cfgu_seq_fsm
  import cfgu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_wr,
  input  logic              dat_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] key,
  output logic              open,
  output logic              abandon
);
  cfgu_state_e state_q, state_d;
  logic        ctrl_sel_q, ctrl_sel_d;
  logic [BYTE_W-1:0] want;

  assign want = next_byte(state_q, key);

  always_comb begin
    state_d    = state_q;
    ctrl_sel_d = ctrl_sel_q;
    abandon    = 1'b0;
    if (state_q == ST_OPEN) begin
      if (idx_wr) begin
        ctrl_sel_d = (wdata == CTRL_IDX);
      end else if (dat_wr && ctrl_sel_q && wdata == EXIT_VAL) begin
        state_d    = ST_IDLE;
        ctrl_sel_d = 1'b0;
      end
    end else if (idx_wr) begin
      if (wdata == want) begin
        case (state_q)
          ST_IDLE: state_d = ST_K1;
          ST_K1:   state_d = ST_K2;
          ST_K2:   state_d = ST_K3;
          default: state_d = ST_OPEN;
        endcase
        ctrl_sel_d = 1'b0;
      end else begin
        abandon = (state_q != ST_IDLE);
        state_d = (wdata == SEQ_B0) ? ST_K1 : ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ctrl_sel_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      ctrl_sel_q <= ctrl_sel_d;
    end
  end

  assign open = (state_q == ST_OPEN);
endmodule

// File: rtl/cfgu_sticky_flag.sv
module cfgu_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (set)  flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/cfgu_unlock.sv
module cfgu_unlock
  import cfgu_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter bit ALT_BASE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr_valid,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              flag_rd,
  output logic              cfg_active,
  output logic              mismatch_flag
);
  logic idx_wr, dat_wr, abandon;
  logic [BYTE_W-1:0] key;

  cfgu_port_decode #(.ADDR_W(ADDR_W), .ALT_BASE(ALT_BASE)) u_dec (
    .valid(io_wr_valid), .addr(io_addr),
    .idx_wr(idx_wr), .dat_wr(dat_wr), .key(key)
  );

  cfgu_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .wdata(io_wdata), .key(key), .open(cfg_active), .abandon(abandon)
  );

  cfgu_sticky_flag u_flag (
    .clk(clk), .rst(rst), .set(abandon), .clr(flag_rd), .flag(mismatch_flag)
  );
endmodule

// File: rtl/cfgu_unlock_chk.sv
module cfgu_unlock_chk
  import cfgu_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter bit ALT_BASE = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              io_wr_valid,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic              flag_rd,
  input logic              cfg_active,
  input logic              mismatch_flag
);
  localparam int BASE_SEL = ALT_BASE ? BASE_ALT : BASE_PRI;
  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE_SEL);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(BASE_SEL + 1);
  localparam logic [7:0] KEY_B = ALT_BASE ? KEY_ALT : KEY_PRI;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!cfg_active && !mismatch_flag));

  // R2
  open_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_active) |-> $past(io_wr_valid && io_addr == IDX_A && io_wdata == KEY_B));

  // R7
  exit_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cfg_active) && !$past(rst)) |->
      $past(io_wr_valid && io_addr == DAT_A && io_wdata == EXIT_VAL));

  // R5
  flag_set_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mismatch_flag) |-> $past(io_wr_valid && io_addr == IDX_A && !cfg_active));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (mismatch_flag && !flag_rd) |=> mismatch_flag);

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !io_wr_valid |=> $stable(cfg_active));
endmodule

bind cfgu_unlock cfgu_unlock_chk #(.ADDR_W(ADDR_W), .ALT_BASE(ALT_BASE)) u_chk (
  .clk(clk), .rst(rst), .io_wr_valid(io_wr_valid), .io_addr(io_addr),
  .io_wdata(io_wdata), .flag_rd(flag_rd), .cfg_active(cfg_active),
  .mismatch_flag(mismatch_flag)
);

// File: tb/tb_cfgu_unlock.sv
module tb_cfgu_unlock;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;
  localparam logic [7:0]  KEY = 8'h55;

  logic clk = 1'b0;
  logic rst, io_wr_valid, flag_rd;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic cfg_active, mismatch_flag;

  int n_vec = 0;
  int n_bad = 0;
  int m_st = 0;
  bit m_sel = 0;
  bit m_flag = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgu_unlock dut (
    .clk(clk), .rst(rst), .io_wr_valid(io_wr_valid), .io_addr(io_addr),
    .io_wdata(io_wdata), .flag_rd(flag_rd), .cfg_active(cfg_active),
    .mismatch_flag(mismatch_flag)
  );

  function automatic logic [7:0] want_byte(int st);
    case (st)
      0: want_byte = 8'h87;
      1: want_byte = 8'h01;
      2: want_byte = 8'h55;
      default: want_byte = KEY;
    endcase
  endfunction

  task automatic model(bit r, bit v, logic [15:0] a, logic [7:0] d, bit rd);
    bit set = 0;
    if (r) begin
      m_st = 0; m_sel = 0; m_flag = 0;
      return;
    end
    if (v && a == IDX) begin
      if (m_st == 4) m_sel = (d == 8'h02);
      else if (d == want_byte(m_st)) begin
        m_st = m_st + 1; m_sel = 0;
      end else begin
        if (m_st != 0) set = 1;
        m_st = (d == 8'h87) ? 1 : 0;
      end
    end else if (v && a == DAT && m_st == 4 && m_sel && d == 8'h02) begin
      m_st = 0; m_sel = 0;
    end
    if (set) m_flag = 1;
    else if (rd) m_flag = 0;
  endtask

  task automatic step(string tag, bit r, bit v, logic [15:0] a,
                      logic [7:0] d, bit rd);
    @(negedge clk);
    rst = r; io_wr_valid = v; io_addr = a; io_wdata = d; flag_rd = rd;
    model(r, v, a, d, rd);
    @(posedge clk);
    #1;
    n_vec++;
    if (cfg_active !== (m_st == 4) || mismatch_flag !== m_flag) begin
      n_bad++;
      $display("FAIL %s: active=%b flag=%b expected active=%b flag=%b",
               tag, cfg_active, mismatch_flag, (m_st == 4), m_flag);
    end
  endtask

  task automatic wr(string tag, logic [15:0] a, logic [7:0] d);
    step(tag, 1'b0, 1'b1, a, d, 1'b0);
  endtask

  task automatic unlock(string tag);
    wr(tag, IDX, 8'h87); wr(tag, IDX, 8'h01);
    wr(tag, IDX, 8'h55); wr(tag, IDX, KEY);
  endtask

  initial begin
    rst = 1; io_wr_valid = 0; io_addr = 0; io_wdata = 0; flag_rd = 0;
    step("R1", 1, 0, 0, 0, 0);
    step("R1", 1, 1, IDX, 8'h87, 0);
    step("R9", 0, 0, 0, 0, 0);
    // R2 plain unlock, then R8 ignored traffic while open
    unlock("R2");
    wr("R8", 16'h0080, 8'h02);
    wr("R8", IDX, 8'h87);
    wr("R8", DAT, 8'h02);
    // R7 exit
    wr("R7", IDX, 8'h02);
    wr("R7", DAT, 8'h03);
    wr("R7", IDX, 8'h07);
    wr("R7", DAT, 8'h02);
    wr("R7", IDX, 8'h02);
    step("R9", 0, 0, 0, 0, 0);
    wr("R7", DAT, 8'h02);
    // R3 wrong key at primary base
    wr("R3", IDX, 8'h87); wr("R3", IDX, 8'h01);
    wr("R3", IDX, 8'h55); wr("R3", IDX, 8'hAA);
    step("R6", 0, 0, 0, 0, 1);
    // R5 stray byte at idle sets nothing
    wr("R5", IDX, 8'h33);
    wr("R8", DAT, 8'h87);
    // R4 restart from each depth on 0x87
    for (int dpt = 1; dpt <= 3; dpt++) begin
      wr("R4", IDX, 8'h87);
      for (int k = 1; k < dpt; k++) wr("R4", IDX, want_byte(k));
      wr("R4", IDX, 8'h87);
      wr("R4", IDX, 8'h01); wr("R4", IDX, 8'h55); wr("R4", IDX, KEY);
      wr("R7", IDX, 8'h02); wr("R7", DAT, 8'h02);
      step("R6", 0, 0, 0, 0, 1);
    end
    // R6 set and clear on the same edge: set wins
    wr("R6", IDX, 8'h87);
    step("R6", 0, 1, IDX, 8'h44, 1);
    step("R6", 0, 0, 0, 0, 1);
    // R2 with gaps and foreign traffic between bytes
    wr("R2", IDX, 8'h87); step("R2", 0, 0, 0, 0, 0);
    wr("R2", 16'h0030, 8'h11); wr("R2", IDX, 8'h01);
    wr("R2", DAT, 8'h55); wr("R2", IDX, 8'h55); wr("R2", IDX, KEY);
    step("R1", 1, 0, 0, 0, 0);
    // random phase
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int sa, sd;
      sa = $urandom_range(0, 9);
      a = (sa < 6) ? IDX : (sa < 9) ? DAT : 16'($urandom_range(0, 255));
      sd = $urandom_range(0, 11);
      case (sd)
        0, 1, 2: d = 8'h87;
        3, 4:    d = 8'h01;
        5, 6:    d = 8'h55;
        7:       d = 8'hAA;
        8, 9:    d = 8'h02;
        default: d = 8'($urandom_range(0, 255));
      endcase
      step("R8", ($urandom_range(0, 199) == 0), ($urandom_range(0, 9) != 0),
           a, d, ($urandom_range(0, 7) == 0));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: active=%b flag=%b expected run to finish",
                 cfg_active, mismatch_flag);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule